// File: doc/BRIEF.md
# Software-Refilled Set-Associative Data TLB

This block translates data-side effective addresses into physical addresses through a small set-associative table. The table is filled only by software. Each lookup takes the page number of the incoming address and uses its low bits to pick one set. It then compares the full stored page number of every way in that set. A hit yields the physical page joined to the untouched page offset, together with the entry's protection bits. A miss produces a one-cycle exception strobe and captures the faulting address so that a handler can refill the table.

Software reaches every entry through a register port addressed by way, set and a select that picks the match half or the translate half. Reads return data in the same cycle. Writes land at the next clock edge. The match half exposes a recency bit per way, and a refill handler picks a way whose bit reads zero. An enable input turns translation off, and in that case addresses pass straight through and no miss is raised.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry reads as zero through the register port, and `rs_valid`, `miss_pulse` and `fault_addr` are all zero.
- R2: A lookup uses set (address >> PAGE_OFS_W) mod SETS. It hits only when a way in that set has its valid bit set and a stored page number equal to all of address bits [ADDR_W-1:PAGE_OFS_W].
- R3: On a hit the result appears one cycle after the lookup with `rs_valid`=1 and `rs_hit`=1. `rs_addr` is the stored physical page joined to the lookup's page offset, and `rs_prot` is the entry's protection field.
- R4: A lookup that misses with translation enabled raises `miss_pulse` for exactly one cycle, in the result cycle, and loads `fault_addr` with the lookup address. At all other times `fault_addr` holds its value.
- R5: A stored page number that differs from the address in any single bit, with a lone one walked across the whole field, gives a miss.
- R6: The first and the last word of a mapped page both hit. The last word of the preceding page and the first word of the following page miss when those pages are unmapped.
- R7: With `xlat_en` low, `rs_addr` equals the lookup address, `rs_hit` and `rs_prot` are zero, and no miss is raised.
- R8: Writing zero to a match entry invalidates it. Zeroing every way of every set leaves no hits.
- R9: Each set keeps one recency bit per way, readable at match-entry bit 1. Touching a way sets its bit, and if that would set all bits, only the touched way's bit stays set. A hit touches the hit way, and a register write touches the written way. A write takes priority when both address the same set in the same cycle.
- R10: `cfg_rdata` reflects the addressed entry in the same cycle. A write is seen by lookups from the next cycle on, so a lookup in the write cycle still sees the old entry.
- R11: Match-entry layout: page number in bits [ADDR_W-1:PAGE_OFS_W], valid in bit 0, recency in bit 1 (read-only), all other bits zero. Translate-entry layout: physical page in bits [ADDR_W-1:PAGE_OFS_W], protection in bits [PROT_W-1:0], all other bits zero. `cfg_sel` 0 selects the match half and 1 selects the translate half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | 1 = translate, 0 = pass addresses through |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Effective address to translate |
| cfg_we | input | 1 | Register port write enable |
| cfg_sel | input | 1 | 0 = match half, 1 = translate half |
| cfg_way | input | WAY_W | Way addressed by the register port |
| cfg_set | input | SET_W | Set addressed by the register port |
| cfg_wdata | input | ADDR_W | Register port write data |
| cfg_rdata | output | ADDR_W | Register port read data, same cycle |
| rs_valid | output | 1 | Lookup result valid (one cycle after request) |
| rs_hit | output | 1 | Result came from a translating hit |
| rs_addr | output | ADDR_W | Physical (or passed-through) address |
| rs_prot | output | PROT_W | Protection bits of the hit entry |
| miss_pulse | output | 1 | One-cycle miss exception strobe |
| fault_addr | output | ADDR_W | Address of the most recent miss |

## Verification
The bench builds the block with a 16-bit address, 256-byte pages, four sets, two ways and a 4-bit protection field. With these values the 8-bit stored page number is short enough to walk a single one through every bit position, including the two set-index bits. Two ways make the recency behaviour fully predictable, and neighbouring pages fall into different sets. The small table can also be cleared and read back completely within a few dozen cycles.

// File: rtl/tlb_pkg.sv
// Shared definitions for the software-refilled TLB.
// Assumes: fields are located by the bit positions given here.
package tlb_pkg;

    // Register port half selector
    typedef enum logic {
        SEL_MATCH = 1'b0,
        SEL_XLAT  = 1'b1
    } cfg_sel_e;

    // Bit positions inside a match entry
    localparam int MATCH_VALID_BIT = 0;
    localparam int MATCH_RECENT_BIT = 1;

endpackage

// File: rtl/tlb_way_store.sv
// One way of the TLB: per-set page number, valid bit, physical page
// and protection field. It has one write port, with the match and the
// translate halves written separately, and two combinational read
// ports: one indexed by the lookup set and one by the register-port set.
// Assumes: write strobes are already qualified for this way.
module tlb_way_store #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFS_W = 13,
    parameter int SETS       = 16,
    parameter int PROT_W     = 4,
    localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int VPN_W     = ADDR_W - PAGE_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_match,
    input  logic              wr_xlat,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [SET_W-1:0]  lk_set,
    output logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_vld,
    output logic [VPN_W-1:0]  lk_ppn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic [SET_W-1:0]  rd_set,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic              rd_vld,
    output logic [VPN_W-1:0]  rd_ppn,
    output logic [PROT_W-1:0] rd_prot
);
    import tlb_pkg::*;

    logic [VPN_W-1:0]  vpn_q  [SETS];
    logic              vld_q  [SETS];
    logic [VPN_W-1:0]  ppn_q  [SETS];
    logic [PROT_W-1:0] prot_q [SETS];

    // Match half storage: clear on reset, load on a match write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vpn_q[s] <= '0;
                vld_q[s] <= 1'b0;
            end
        end else if (wr_match) begin
            vpn_q[wr_set] <= wr_data[ADDR_W-1:PAGE_OFS_W];
            vld_q[wr_set] <= wr_data[MATCH_VALID_BIT];
        end
    end

    // Translate half storage: clear on reset, load on a translate write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ppn_q[s]  <= '0;
                prot_q[s] <= '0;
            end
        end else if (wr_xlat) begin
            ppn_q[wr_set]  <= wr_data[ADDR_W-1:PAGE_OFS_W];
            prot_q[wr_set] <= wr_data[PROT_W-1:0];
        end
    end

    // Lookup-side read
    always_comb begin
        lk_vpn  = vpn_q[lk_set];
        lk_vld  = vld_q[lk_set];
        lk_ppn  = ppn_q[lk_set];
        lk_prot = prot_q[lk_set];
    end

    // Register-port-side read
    always_comb begin
        rd_vpn  = vpn_q[rd_set];
        rd_vld  = vld_q[rd_set];
        rd_ppn  = ppn_q[rd_set];
        rd_prot = prot_q[rd_set];
    end

endmodule

// File: rtl/tlb_compare.sv
// Compares the lookup page number with every way of the indexed set
// and selects the lowest-numbered matching way.
// Assumes: software normally avoids duplicate mappings; on a duplicate
// the lowest way wins.
module tlb_compare #(
    parameter int WAYS   = 2,
    parameter int VPN_W  = 19,
    parameter int PROT_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [VPN_W-1:0]             lk_vpn,
    input  logic [WAYS-1:0][VPN_W-1:0]   way_vpn,
    input  logic [WAYS-1:0]              way_vld,
    input  logic [WAYS-1:0][VPN_W-1:0]   way_ppn,
    input  logic [WAYS-1:0][PROT_W-1:0]  way_prot,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic [VPN_W-1:0]             hit_ppn,
    output logic [PROT_W-1:0]            hit_prot
);
    logic [WAYS-1:0] match_vec;

    // One full-width comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_vld[w] && (way_vpn[w] == lk_vpn);
    end

    assign hit = |match_vec;

    // Priority pick: lowest matching way
    always_comb begin
        hit_way  = '0;
        hit_ppn  = '0;
        hit_prot = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                hit_way  = WAY_W'(w);
                hit_ppn  = way_ppn[w];
                hit_prot = way_prot[w];
            end
        end
    end

endmodule

// File: rtl/tlb_recency.sv
// Per-set recency bits, one per way. Touching a way sets its bit, and
// if every bit would then be set, only the touched bit remains.
// A register write has priority over a hit that addresses the same set.
// Assumes: WAYS >= 2 for the bits to be meaningful.
module tlb_recency #(
    parameter int SETS   = 16,
    parameter int WAYS   = 2,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_touch,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             hit_touch,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAYS-1:0]  rd_bits
);
    logic [WAYS-1:0] used_q [SETS];

    // Compute the recency vector after touching one way
    function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] old,
                                             input logic [WAY_W-1:0] w);
        logic [WAYS-1:0] one;
        one    = '0;
        one[w] = 1'b1;
        if (&(old | one)) return one;
        return old | one;
    endfunction

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Update one set's recency bits from a write or a hit
        always_ff @(posedge clk) begin
            if (!rst_n)
                used_q[s] <= '0;
            else if (wr_touch && (wr_set == SET_W'(s)))
                used_q[s] <= touch(used_q[s], wr_way);
            else if (hit_touch && (hit_set == SET_W'(s)))
                used_q[s] <= touch(used_q[s], hit_way);
        end
    end

    assign rd_bits = used_q[rd_set];

endmodule

// File: rtl/soft_tlb.sv
// Software-refilled set-associative data TLB. It looks up one set per
// request, registers the result with one cycle of latency, raises a
// one-cycle miss strobe and captures the faulting address. A register
// port gives same-cycle reads and next-edge writes of every entry.
// Assumes: SETS and WAYS are powers of two; PROT_W < PAGE_OFS_W;
// PAGE_OFS_W >= 2.
module soft_tlb #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFS_W = 13,
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int PROT_W     = 4,
    localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int VPN_W     = ADDR_W - PAGE_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WAY_W-1:0]  cfg_way,
    input  logic [SET_W-1:0]  cfg_set,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [ADDR_W-1:0] rs_addr,
    output logic [PROT_W-1:0] rs_prot,
    output logic              miss_pulse,
    output logic [ADDR_W-1:0] fault_addr
);
    import tlb_pkg::*;

    logic [SET_W-1:0] lk_set;
    logic [VPN_W-1:0] lk_vpn;

    logic [WAYS-1:0][VPN_W-1:0]  lw_vpn;
    logic [WAYS-1:0]             lw_vld;
    logic [WAYS-1:0][VPN_W-1:0]  lw_ppn;
    logic [WAYS-1:0][PROT_W-1:0] lw_prot;
    logic [WAYS-1:0][VPN_W-1:0]  rw_vpn;
    logic [WAYS-1:0]             rw_vld;
    logic [WAYS-1:0][VPN_W-1:0]  rw_ppn;
    logic [WAYS-1:0][PROT_W-1:0] rw_prot;

    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [VPN_W-1:0]  hit_ppn;
    logic [PROT_W-1:0] hit_prot;
    logic [WAYS-1:0]   recent_bits;
    logic              xlat_lookup;

    assign lk_set      = lk_addr[PAGE_OFS_W +: SET_W];
    assign lk_vpn      = lk_addr[ADDR_W-1:PAGE_OFS_W];
    assign xlat_lookup = lk_valid && xlat_en;

    // One storage slice per way, write strobes decoded per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic sel_this;
        assign sel_this = cfg_we && (cfg_way == WAY_W'(w));

        tlb_way_store #(
            .ADDR_W(ADDR_W), .PAGE_OFS_W(PAGE_OFS_W),
            .SETS(SETS), .PROT_W(PROT_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_match(sel_this && (cfg_sel_e'(cfg_sel) == SEL_MATCH)),
            .wr_xlat (sel_this && (cfg_sel_e'(cfg_sel) == SEL_XLAT)),
            .wr_set  (cfg_set),
            .wr_data (cfg_wdata),
            .lk_set  (lk_set),
            .lk_vpn  (lw_vpn[w]),
            .lk_vld  (lw_vld[w]),
            .lk_ppn  (lw_ppn[w]),
            .lk_prot (lw_prot[w]),
            .rd_set  (cfg_set),
            .rd_vpn  (rw_vpn[w]),
            .rd_vld  (rw_vld[w]),
            .rd_ppn  (rw_ppn[w]),
            .rd_prot (rw_prot[w])
        );
    end

    tlb_compare #(
        .WAYS(WAYS), .VPN_W(VPN_W), .PROT_W(PROT_W)
    ) u_cmp (
        .lk_vpn  (lk_vpn),
        .way_vpn (lw_vpn),
        .way_vld (lw_vld),
        .way_ppn (lw_ppn),
        .way_prot(lw_prot),
        .hit     (hit),
        .hit_way (hit_way),
        .hit_ppn (hit_ppn),
        .hit_prot(hit_prot)
    );

    tlb_recency #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_touch (cfg_we),
        .wr_set   (cfg_set),
        .wr_way   (cfg_way),
        .hit_touch(xlat_lookup && hit),
        .hit_set  (lk_set),
        .hit_way  (hit_way),
        .rd_set   (cfg_set),
        .rd_bits  (recent_bits)
    );

    // Register-port read data assembled from the addressed way
    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel_e'(cfg_sel) == SEL_MATCH) begin
            cfg_rdata[ADDR_W-1:PAGE_OFS_W] = rw_vpn[cfg_way];
            cfg_rdata[MATCH_RECENT_BIT]    = recent_bits[cfg_way];
            cfg_rdata[MATCH_VALID_BIT]     = rw_vld[cfg_way];
        end else begin
            cfg_rdata[ADDR_W-1:PAGE_OFS_W] = rw_ppn[cfg_way];
            cfg_rdata[PROT_W-1:0]          = rw_prot[cfg_way];
        end
    end

    // Result register: translated, passed-through or missed lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_addr  <= '0;
            rs_prot  <= '0;
        end else begin
            rs_valid <= lk_valid;
            if (lk_valid) begin
                if (!xlat_en) begin
                    rs_hit  <= 1'b0;
                    rs_addr <= lk_addr;
                    rs_prot <= '0;
                end else begin
                    rs_hit  <= hit;
                    rs_addr <= {hit_ppn, lk_addr[PAGE_OFS_W-1:0]};
                    rs_prot <= hit_prot;
                end
            end
        end
    end

    // Miss strobe and fault-address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_pulse <= 1'b0;
            fault_addr <= '0;
        end else begin
            miss_pulse <= xlat_lookup && !hit;
            if (xlat_lookup && !hit)
                fault_addr <= lk_addr;
        end
    end

endmodule

// File: rtl/soft_tlb_chk.sv
// Protocol checker for soft_tlb, attached with bind.
// Assumes: the reset is held for at least one clock edge.
module soft_tlb_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_en,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rs_valid,
    input logic              rs_hit,
    input logic [ADDR_W-1:0] rs_addr,
    input logic              miss_pulse,
    input logic [ADDR_W-1:0] fault_addr
);
    // R4
    miss_needs_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> ($past(lk_valid) && $past(xlat_en)));

    // R4
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> (fault_addr == $past(lk_addr)));

    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_pulse |-> $stable(fault_addr));

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_valid) && !$past(xlat_en)) |-> (rs_addr == $past(lk_addr) && !miss_pulse && !rs_hit));

    // R3
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid == $past(lk_valid));

    // R2
    hit_excludes_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> !miss_pulse);
endmodule

bind soft_tlb soft_tlb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rs_valid  (rs_valid),
    .rs_hit    (rs_hit),
    .rs_addr   (rs_addr),
    .miss_pulse(miss_pulse),
    .fault_addr(fault_addr)
);

// File: tb/sim_soft_tlb.sv
`timescale 1ns/1ps
module sim_soft_tlb;
    localparam int AW = 16;
    localparam int PO = 8;
    localparam int NS = 4;
    localparam int NW = 2;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xlat_en = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [0:0]    cfg_way = '0;
    logic [1:0]    cfg_set = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          rs_valid, rs_hit, miss_pulse;
    logic [AW-1:0] rs_addr, fault_addr;
    logic [PW-1:0] rs_prot;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    soft_tlb #(.ADDR_W(AW), .PAGE_OFS_W(PO), .SETS(NS), .WAYS(NW), .PROT_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_way(cfg_way), .cfg_set(cfg_set),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_addr(rs_addr), .rs_prot(rs_prot), .miss_pulse(miss_pulse), .fault_addr(fault_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register port write; lands at the edge between the two negedges
    task automatic wr(input logic sel, input int way, input int set, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_way = way[0:0]; cfg_set = set[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic sel, input int way, input int set,
                          input logic [AW-1:0] exp);
        @(negedge clk);
        cfg_sel = sel; cfg_way = way[0:0]; cfg_set = set[1:0];
        #1 chk(req, cfg_rdata, exp);
    endtask

    // One lookup; outputs are sampled in the result cycle
    task automatic look(input logic [AW-1:0] a, input logic en);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; xlat_en = en;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic look_hit(input string req, input logic [AW-1:0] a, input logic [AW-1:0] pa,
                            input logic [PW-1:0] pr);
        look(a, 1'b1);
        chk({req, " valid"}, rs_valid, 1);
        chk({req, " hit"}, rs_hit, 1);
        chk({req, " addr"}, rs_addr, pa);
        chk({req, " prot"}, rs_prot, pr);
        chk({req, " no miss"}, miss_pulse, 0);
    endtask

    task automatic look_miss(input string req, input logic [AW-1:0] a);
        look(a, 1'b1);
        chk({req, " miss"}, miss_pulse, 1);
        chk({req, " hit"}, rs_hit, 0);
        chk({req, " fault"}, fault_addr, a);
    endtask

    task automatic t_reset();
        chk("R1 rs_valid", rs_valid, 0);
        chk("R1 miss", miss_pulse, 0);
        chk("R1 fault", fault_addr, 0);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin
                rd_chk("R1 match entry", 1'b0, w, s, 16'h0000);
                rd_chk("R1 xlat entry", 1'b1, w, s, 16'h0000);
            end
    endtask

    // Page 0x31 (set 1) -> 0xA5, prot 9, in way 0
    task automatic t_map_hit();
        wr(1'b0, 0, 1, 16'h3101);
        wr(1'b1, 0, 1, 16'hA509);
        rd_chk("R11 xlat layout", 1'b1, 0, 1, 16'hA509);
        look_hit("R3 first word", 16'h3100, 16'hA500, 4'h9);
        look_hit("R6 last word", 16'h31FF, 16'hA5FF, 4'h9);
        look_hit("R2 mid word", 16'h3142, 16'hA542, 4'h9);
    endtask

    task automatic t_boundary();
        look_miss("R6 prev page", 16'h30FC);
        @(negedge clk);
        chk("R4 one-cycle pulse", miss_pulse, 0);
        chk("R4 fault holds", fault_addr, 16'h30FC);
        look_miss("R6 next page", 16'h3200);
    endtask

    task automatic t_walk();
        for (int b = 0; b < 8; b++) begin
            logic [7:0] v;
            v = 8'h31 ^ (8'h01 << b);
            look_miss("R5 walked bit", {v, 8'h10});
        end
        look_hit("R5 exact still hits", 16'h3110, 16'hA510, 4'h9);
    endtask

    task automatic t_recency();
        // way0 set1 recency is 01 after the hits; writing way1 would make 11 -> 10
        wr(1'b0, 1, 1, 16'h3501);
        rd_chk("R9 way0 after way1 write", 1'b0, 0, 1, 16'h3101);
        rd_chk("R9 way1 after write", 1'b0, 1, 1, 16'h3503);
        wr(1'b1, 1, 1, 16'h5C03);
        rd_chk("R11 way1 xlat", 1'b1, 1, 1, 16'h5C03);
        look_hit("R2 second way", 16'h3540, 16'h5C40, 4'h3);
        look_hit("R9 hit way0", 16'h3100, 16'hA500, 4'h9);
        rd_chk("R9 way0 most recent", 1'b0, 0, 1, 16'h3103);
        rd_chk("R9 way1 now zero", 1'b0, 1, 1, 16'h3501);
    endtask

    task automatic t_pass();
        look(16'h7777, 1'b0);
        chk("R7 addr", rs_addr, 16'h7777);
        chk("R7 no miss", miss_pulse, 0);
        chk("R7 hit low", rs_hit, 0);
        chk("R7 prot zero", rs_prot, 0);
        chk("R7 fault unchanged", fault_addr, 16'h3110 ^ 16'h8000);
        look(16'h3100, 1'b0);
        chk("R7 mapped passes", rs_addr, 16'h3100);
    endtask

    // Write and lookup in the same cycle: lookup still sees the old entry
    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_way = 1'b0; cfg_set = 2'd1; cfg_wdata = 16'h0000;
        lk_valid = 1'b1; lk_addr = 16'h3100; xlat_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        chk("R10 old entry used", rs_hit, 1);
        chk("R10 old addr", rs_addr, 16'hA500);
        look_miss("R8 invalidated", 16'h3100);
    endtask

    task automatic t_clear_all();
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++)
                wr(1'b0, w, s, 16'h0000);
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++)
                rd_chk("R8 cleared", 1'b0, w, s, {14'h0, (s == 3 && w == 1) ? 1'b1 : 1'b0, 1'b0} & 16'h0000
                       | ((w == 1) ? 16'h0002 : 16'h0000));
        look_miss("R8 no hit after clear", 16'h3540);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_hit();
        t_boundary();
        t_walk();
        t_recency();
        t_pass();
        t_same_cycle();
        t_clear_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule